// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block holds one tag per cache line and answers, in one clock, whether the tag presented on the address bus matches the tag stored for that line. The address bus is split into a line index (the low `IDX_W` bits) and a tag field (the `TAG_W` bits above it). A single set of controls selects what happens each cycle: wipe the whole store, stay idle, write a tag, read a tag back, or compare. The default build has 8192 lines of 8-bit tags, which covers a 21-bit address.

The hit output idles high and only a compare that finds a different tag pulls it low. Several instances can therefore share the index and each compare its own slice of a wider tag, and the AND of their hit outputs is the hit for the full width. A whole-store clear, from a clear request or the reset input, makes every line read and compare as zero at the next clock. It clears a per-line valid bit rather than sweeping the array. A programmable recovery window after a clear rejects early writes and reports each one on an error output.

Sequencing is held in a three-state machine. `ST_CLEAR` is entered on any clock where clear or reset is sampled. On the first clock without clear it moves to `ST_RECOVER`, loaded with `RECOVER_CYC-1` remaining cycles, or straight to `ST_READY` when `RECOVER_CYC` is 0 or 1. `ST_RECOVER` counts down and moves to `ST_READY` on its last cycle. Any clear returns the machine to `ST_CLEAR` from every state.

Top module: `tag_cache_store`

## Requirements
- R1: The store holds 2**IDX_W independent words of TAG_W bits. Address bits [IDX_W-1:0] pick the word and bits [IDX_W+TAG_W-1:IDX_W] form the tag field. A write stores the tag field into the picked word, and a later read of that index returns it.
- R2: A clock with clr_req=1 or rst=1 sets every word to zero, whatever sel, wr_en and rd_oe are. From the next clock, every read returns 0 and a compare against tag 0 hits.
- R3: Each sampled cycle has one operation, decoded in this priority: clear (clr_req or rst), deselect (sel=0), write (wr_en=1), read (rd_oe=1), otherwise compare. A write or read request with sel=0 changes nothing.
- R4: In the clock after a compare cycle, hit is 1 if the stored word at the index equals the tag field and 0 if it differs.
- R5: In the clock after any cycle that is not a compare (clear, deselect, write, read), hit is 1.
- R6: In the clock after a read cycle, dout_en is 1 and dout carries the stored word. After every other cycle, dout_en is 0 and dout is all zeros.
- R7: A write is accepted only when sel=1 and wr_en=1 and it commits at that clock edge. The setting of rd_oe has no effect on the write. dout_en is 0 in the following clock.
- R8: A write requested in any of the RECOVER_CYC cycles that follow the last clear cycle is dropped and leaves the store unchanged. wr_err is 1 in the clock after each dropped request and 0 otherwise. The first write after the window is accepted.
- R9: When clear and a write are requested in the same cycle, the clear wins. The word stays zero and wr_err stays 0.
- R10: Two instances sharing index and controls, each comparing its own tag slice, give a full-width hit equal to the AND of their hit outputs. The combined hit is 0 when either slice misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All controls are sampled on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. It also clears the store. |
| clr_req | input | 1 | Whole-store clear request, active high. |
| sel | input | 1 | Chip select, active high. |
| wr_en | input | 1 | Write request, active high. |
| rd_oe | input | 1 | Read output enable, active high. |
| addr | input | IDX_W+TAG_W | Line index in the low bits and tag field in the high bits. |
| dout | output | TAG_W | Read data, all zeros when not enabled. |
| dout_en | output | 1 | High in the clock after a read. |
| hit | output | 1 | Compare result, idles high, low only on a compare miss. |
| wr_err | output | 1 | High in the clock after a write dropped in the recovery window. |

## Verification
The bench builds two instances with IDX_W=4, TAG_W=4 and RECOVER_CYC=2. At this size every one of the 16 lines can be compared against every one of the 16 tag values. The clear-and-write collision and the two-cycle recovery window each take only a few clocks to reach. The second instance stores a tag offset from the first, so one full-width hit and one slice-only miss can be produced and the AND rule checked.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    // Operation decoded from the sampled controls, in priority order.
    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_DESEL   = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_COMPARE = 3'd4
    } op_t;

    // Clear / recovery sequencing.
    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_RECOVER = 2'd1,
        ST_READY   = 2'd2
    } rec_t;

endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
    import tagram_pkg::*;
#(
    parameter int RECOVER_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_req,
    input  logic sel,
    input  logic wr_en,
    input  logic rd_oe,
    output op_t  op,
    output logic clr_all,
    output logic wr_go,
    output logic wr_err
);

    localparam int CW = $clog2(RECOVER_CYC + 2);
    localparam logic [CW-1:0] CNT_LOAD = CW'((RECOVER_CYC > 0) ? RECOVER_CYC - 1 : 0);
    localparam bit WIN_AFTER_CLR = (RECOVER_CYC > 0);
    localparam bit SKIP_RECOVER  = (RECOVER_CYC <= 1);

    rec_t          state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          in_window;

    assign clr_all = rst | clr_req;

    // Operation decode with fixed priority.
    always_comb begin
        if (clr_all)      op = OP_CLEAR;
        else if (!sel)    op = OP_DESEL;
        else if (wr_en)   op = OP_WRITE;
        else if (rd_oe)   op = OP_READ;
        else              op = OP_COMPARE;
    end

    assign in_window = (state == ST_RECOVER) || ((state == ST_CLEAR) && WIN_AFTER_CLR);
    assign wr_go     = (op == OP_WRITE) && !in_window;

    // Next state.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_CLEAR: begin
                cnt_nx   = CNT_LOAD;
                state_nx = SKIP_RECOVER ? ST_READY : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (cnt <= CW'(1)) begin
                    cnt_nx   = '0;
                    state_nx = ST_READY;
                end else begin
                    cnt_nx   = cnt - CW'(1);
                end
            end
            ST_READY: begin
                state_nx = ST_READY;
            end
            default: state_nx = ST_CLEAR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (clr_all) begin
            state <= ST_CLEAR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Registered output.
    always_ff @(posedge clk) begin
        if (clr_all) wr_err <= 1'b0;
        else         wr_err <= (op == OP_WRITE) && in_window;
    end

endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
    parameter int IDX_W = 13,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             clr_all,
    input  logic             wr_go,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wdata,
    output logic [TAG_W-1:0] rd_word
);

    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] line_ok;

    // Tag storage: no reset, validity lives in line_ok.
    always_ff @(posedge clk) begin
        if (wr_go && !clr_all) mem[idx] <= wdata;
    end

    // Per-line valid bits, flash-cleared in one clock.
    always_ff @(posedge clk) begin
        if (clr_all)    line_ok <= '0;
        else if (wr_go) line_ok[idx] <= 1'b1;
    end

    // Registered read; an invalid line reads as zero.
    always_ff @(posedge clk) begin
        rd_word <= line_ok[idx] ? mem[idx] : '0;
    end

endmodule

// File: rtl/tagram_out.sv
module tagram_out
    import tagram_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  op_t              op,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [TAG_W-1:0] rd_word,
    output logic             hit,
    output logic [TAG_W-1:0] dout,
    output logic             dout_en
);

    op_t              op_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        op_q  <= op;
        tag_q <= tag_in;
    end

    always_comb begin
        hit     = 1'b1;
        dout_en = 1'b0;
        dout    = '0;
        unique case (op_q)
            OP_COMPARE: hit = (rd_word == tag_q);
            OP_READ: begin
                dout_en = 1'b1;
                dout    = rd_word;
            end
            OP_CLEAR, OP_DESEL, OP_WRITE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/tag_cache_store.sv
module tag_cache_store
    import tagram_pkg::*;
#(
    parameter int IDX_W       = 13,
    parameter int TAG_W       = 8,
    parameter int RECOVER_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_req,
    input  logic                   sel,
    input  logic                   wr_en,
    input  logic                   rd_oe,
    input  logic [IDX_W+TAG_W-1:0] addr,
    output logic [TAG_W-1:0]       dout,
    output logic                   dout_en,
    output logic                   hit,
    output logic                   wr_err
);

    localparam int ADDR_W = IDX_W + TAG_W;

    op_t              op;
    logic             clr_all;
    logic             wr_go;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag_f;
    logic [TAG_W-1:0] rd_word;

    assign idx   = addr[IDX_W-1:0];
    assign tag_f = addr[ADDR_W-1:IDX_W];

    tagram_ctrl #(.RECOVER_CYC(RECOVER_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .clr_req(clr_req), .sel(sel), .wr_en(wr_en),
        .rd_oe(rd_oe), .op(op), .clr_all(clr_all), .wr_go(wr_go), .wr_err(wr_err)
    );

    tagram_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk(clk), .clr_all(clr_all), .wr_go(wr_go), .idx(idx),
        .wdata(tag_f), .rd_word(rd_word)
    );

    tagram_out #(.TAG_W(TAG_W)) u_out (
        .clk(clk), .op(op), .tag_in(tag_f), .rd_word(rd_word),
        .hit(hit), .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/tagram_chk.sv
module tagram_chk #(
    parameter int ADDR_W = 21,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_req,
    input logic              sel,
    input logic              wr_en,
    input logic              rd_oe,
    input logic [ADDR_W-1:0] addr,
    input logic [TAG_W-1:0]  dout,
    input logic              dout_en,
    input logic              hit,
    input logic              wr_err
);

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_req) || !$past(sel) || $past(wr_en) || $past(rd_oe)) |-> hit);

    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

    assert_read_only_R6: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(sel && !wr_en && rd_oe && !clr_req));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(sel && wr_en && !clr_req));

    assert_clear_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $past(clr_req) |-> (hit && !dout_en && !wr_err));

    assert_addr_known_R1: assert property (@(posedge clk) disable iff (rst)
        sel |-> !$isunknown(addr));

endmodule

bind tag_cache_store tagram_chk #(.ADDR_W(IDX_W + TAG_W), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst(rst), .clr_req(clr_req), .sel(sel), .wr_en(wr_en),
    .rd_oe(rd_oe), .addr(addr), .dout(dout), .dout_en(dout_en),
    .hit(hit), .wr_err(wr_err)
);

// File: tb/sim_tag_cache_store.sv
`timescale 1ns/1ps
module sim_tag_cache_store;

    localparam int IW = 4;
    localparam int TW = 4;
    localparam int N  = 1 << IW;
    localparam int SL = 4'hA;   // tag offset held by the second slice

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_req = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_oe = 1'b0;
    logic [IW+TW-1:0] addr0 = '0, addr1 = '0;
    logic [TW-1:0] dout0, dout1;
    logic dout_en0, dout_en1, hit0, hit1, err0, err1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_t [N];

    always #2 clk = ~clk;

    tag_cache_store #(.IDX_W(IW), .TAG_W(TW), .RECOVER_CYC(2)) u0 (
        .clk(clk), .rst(rst), .clr_req(clr_req), .sel(sel), .wr_en(wr_en),
        .rd_oe(rd_oe), .addr(addr0), .dout(dout0), .dout_en(dout_en0),
        .hit(hit0), .wr_err(err0));

    tag_cache_store #(.IDX_W(IW), .TAG_W(TW), .RECOVER_CYC(2)) u1 (
        .clk(clk), .rst(rst), .clr_req(clr_req), .sel(sel), .wr_en(wr_en),
        .rd_oe(rd_oe), .addr(addr1), .dout(dout1), .dout_en(dout_en1),
        .hit(hit1), .wr_err(err1));

    function automatic int fval(int i);
        return (i * 7 + 3) % 16;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle: drive after the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic c, input logic s, input logic w, input logic o,
                        input int ix, input int tg, input int tg1 = -1);
        @(negedge clk);
        clr_req = c; sel = s; wr_en = w; rd_oe = o;
        addr0 = {TW'(tg), IW'(ix)};
        addr1 = {TW'((tg1 < 0) ? (tg ^ SL) : tg1), IW'(ix)};
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0);
        chk("R5 reset hit", hit0, 1);
        chk("R6 reset dout_en", dout_en0, 0);
        chk("R6 reset dout", dout0, 0);
        chk("R8 reset wr_err", err0, 0);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);

        // R2: after reset every line compares as zero
        for (int i = 0; i < N; i++) begin
            step(0, 1, 0, 0, i, 0);
            chk("R2 zero hit", hit0, 1);
            step(0, 1, 0, 0, i, 5);
            chk("R4 zero miss", hit0, 0);
        end

        // R7: writes
        for (int i = 0; i < N; i++) begin
            step(0, 1, 1, 0, i, fval(i));
            exp_t[i] = fval(i);
            chk("R7 write dout_en", dout_en0, 0);
            chk("R5 write hit", hit0, 1);
            chk("R8 no err", err0, 0);
        end

        // R1/R6: reads
        for (int i = 0; i < N; i++) begin
            step(0, 1, 0, 1, i, 0);
            chk("R6 read dout_en", dout_en0, 1);
            chk("R1 read data", dout0, exp_t[i]);
            chk("R5 read hit", hit0, 1);
        end

        // R4: exhaustive compare
        for (int i = 0; i < N; i++) begin
            for (int t = 0; t < 16; t++) begin
                step(0, 1, 0, 0, i, t);
                chk("R4 compare", hit0, (t == exp_t[i]) ? 1 : 0);
                chk("R6 compare dout_en", dout_en0, 0);
            end
        end

        // R10: cascade of two slices
        for (int i = 0; i < N; i++) begin
            step(0, 1, 0, 0, i, exp_t[i]);
            chk("R10 full hit", hit0 & hit1, 1);
            step(0, 1, 0, 0, i, exp_t[i], exp_t[i]);
            chk("R10 slice0 hit", hit0, 1);
            chk("R10 slice1 miss", hit0 & hit1, 0);
        end

        // R3/R5: deselect
        step(0, 0, 0, 0, 3, exp_t[3] ^ 1);
        chk("R5 deselect hit", hit0, 1);
        step(0, 0, 1, 0, 3, 0);
        chk("R3 deselected write dout_en", dout_en0, 0);
        step(0, 1, 0, 1, 3, 0);
        chk("R3 deselected write ignored", dout0, exp_t[3]);

        // R3/R7: write with output enable set
        step(0, 1, 1, 1, 2, 9);
        exp_t[2] = 9;
        chk("R7 write with oe dout_en", dout_en0, 0);
        step(0, 1, 0, 1, 2, 0);
        chk("R7 write with oe data", dout0, 9);

        // R9: clear wins over write
        step(1, 1, 1, 0, 5, 6);
        for (int i = 0; i < N; i++) exp_t[i] = 0;
        chk("R9 clear hit", hit0, 1);
        chk("R9 clear dout_en", dout_en0, 0);
        chk("R9 clear wr_err", err0, 0);

        // R8: recovery window of 2 cycles
        step(0, 1, 1, 0, 1, 4);
        chk("R8 drop 1", err0, 1);
        step(0, 1, 1, 0, 1, 4);
        chk("R8 drop 2", err0, 1);
        step(0, 1, 1, 0, 1, 7);
        exp_t[1] = 7;
        chk("R8 accept", err0, 0);

        for (int i = 0; i < N; i++) begin
            step(0, 1, 0, 1, i, 0);
            chk("R2 cleared read", dout0, exp_t[i]);
        end

        // R2: clear regardless of compare controls
        step(1, 1, 0, 0, 1, 3);
        chk("R5 clear during compare", hit0, 1);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 1, 0);
        chk("R2 clear zeroes line", hit0, 1);
        step(0, 1, 0, 0, 1, 7);
        chk("R2 old tag gone", hit0, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule